// File: doc/BRIEF.md
# HDLC Frame Transmitter with Abort

This block turns a queue of bytes into a bit-oriented HDLC line signal. Software-side logic writes each byte into a four-entry transmit queue together with a two-bit tag. The tag tells the transmitter whether more bytes follow, whether the byte closes the frame and must be followed by a frame check sequence (FCS), or whether it closes the frame with no FCS. The transmitter emits one line bit for every strobe of `bit_en`, which comes from an external transmit bit clock.

The first byte queued while the line is idle starts a frame. The block sends the opening flag on its own and presets the CRC generator. It then sends the data bytes with zero-bit insertion. If the tag asks for one, it adds the inverted CRC-16, and it finishes with a closing flag.

Two error cases are handled. If the queue runs dry inside a frame, the block sends either an abort byte or a flag, depending on a configuration input. An abort command waits for the current byte to finish, then sends the abort byte, discards everything still queued and returns to idle. While idle, the line carries either repeated flags or constant ones.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the line output `tx_bit` becomes 1, the queue becomes empty (`fifo_full` is 0) and the block becomes idle.
- R2: When no frame is in progress, the line carries repeated flags 0x7E if `idle_flags` is 1, and constant ones if it is 0; neither is bit-stuffed.
- R3: `tx_bit` changes only on clock edges where `bit_en` is 1, by one bit per strobe, and every byte goes out least significant bit first. When a byte is queued into an idle block, the block sends an opening flag 0x7E, then the frame bytes in queue order.
- R4: A byte queued with tag 2'b01 ends the frame. It is followed by the FCS and then a closing flag 0x7E. The FCS is the ones' complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) over the frame bytes, sent low byte first.
- R5: A byte queued with tag 2'b10 ends the frame and is followed directly by a closing flag, with no FCS. Tag 2'b00 (and 2'b11) means more bytes follow. Frames are always whole bytes.
- R6: In data and FCS fields, a 0 is inserted after every run of five consecutive 1 bits. Flags and the abort byte are never stuffed.
- R7: If the queue is empty when the next data byte is due and `underflow_abort` is 1, the block sends the abort byte 0xFE (a 0 then seven 1s) and goes idle.
- R8: If the queue is empty when the next data byte is due and `underflow_abort` is 0, the block sends a flag 0x7E, which closes the frame, and goes idle.
- R9: A one-cycle pulse on `abort_cmd` takes effect at the next byte boundary. At that point the block sends 0xFE, empties the queue and goes idle.
- R10: The queue holds four entries. `fifo_full` is 1 while four entries are held, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per line bit from the transmit bit clock |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_tag | input | 2 | 00 more follows, 01 last byte with FCS, 10 last byte without FCS |
| abort_cmd | input | 1 | One-cycle abort request |
| underflow_abort | input | 1 | 1: send abort on underflow, 0: send flag on underflow |
| idle_flags | input | 1 | 1: idle line sends flags, 0: idle line sends ones |
| fifo_full | output | 1 | Queue holds four entries |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench runs a line decoder on the output and goes after the cases a framer most often gets wrong.

- **Runs of ones that must be stuffed.** The frame bytes are 0xFF and 0x7E. A missing stuffed zero makes the decoder see a false flag mid-frame. A stuffed flag never parses as a delimiter.
- **FCS byte order and inversion.** A wrong byte order or a missing inversion fails the comparison against the bench's own CRC.
- **Both underflow choices.** Sending the wrong underflow byte either yields a spurious one-byte frame or loses it.
- **Abort with a full queue.** The abort is issued while the queue holds four bytes and underflow is configured to close with a flag. A design that aborts without emptying the queue would later send those four bytes as a frame.

// File: rtl/hdlc_tx_pkg.sv
// Shared types and the CRC step for the HDLC transmitter.
// Assumes CRC-16 in reflected form (poly 0x8408), data fed LSB first.
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'hFE;
    localparam logic [7:0] ONES_BYTE  = 8'hFF;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REF = 16'h8408;

    typedef enum logic [1:0] {
        TAG_MORE    = 2'b00,
        TAG_END_FCS = 2'b01,
        TAG_END_RAW = 2'b10
    } byte_tag_e;

    typedef struct packed {
        logic [1:0]        tag;
        logic [BYTE_W-1:0] data;
    } q_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE
    } tx_state_e;

    // Advance the reflected CRC-16 by one byte, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REF;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
// Small synchronous transmit queue of tagged bytes.
// Assumes pop is only asserted when not empty; flush has priority over all.
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  q_entry_t wr_entry,
    input  logic     pop,
    input  logic     flush,
    output q_entry_t rd_entry,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_entry_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   count;
    logic            do_wr, do_rd;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign do_wr    = wr_en && !full && !flush;
    assign do_rd    = pop && !empty && !flush;
    assign rd_entry = mem[rptr];

    // Store incoming entries.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_entry;
    end

    // Move pointers and occupancy; flush clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop && !flush) |=> (count == $past(count)));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/hdlc_tx_bitgen.sv
// Serializes one byte-sized unit at a time, LSB first, one bit per strobe.
// Stuffs a zero after five ones inside units marked for stuffing.
// Requests the next unit when the current one, including any stuffed zero, is done.
module hdlc_tx_bitgen
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] unit_byte,
    input  logic              unit_stuff,
    output logic              unit_req,
    output logic              tx_bit
);
    localparam int RW = $clog2(BYTE_W);

    logic [BYTE_W-2:0] shreg;
    logic [RW-1:0]     bits_left;
    logic              stuff_on;
    logic [2:0]        ones_run;
    logic              zero_due;
    logic              cur_bit, cur_stuff;

    assign unit_req = bit_en && (bits_left == '0) && !zero_due;

    // Pick the bit to send: first bit of a new unit or the next shifted bit.
    always_comb begin
        if (bits_left == '0) begin
            cur_bit   = unit_byte[0];
            cur_stuff = unit_stuff;
        end else begin
            cur_bit   = shreg[0];
            cur_stuff = stuff_on;
        end
    end

    // Drive the line, shift the unit and track runs of ones for stuffing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit    <= 1'b1;
            shreg     <= '0;
            bits_left <= '0;
            stuff_on  <= 1'b0;
            ones_run  <= '0;
            zero_due  <= 1'b0;
        end else if (bit_en) begin
            if (zero_due) begin
                tx_bit   <= 1'b0;
                zero_due <= 1'b0;
                ones_run <= '0;
            end else begin
                tx_bit <= cur_bit;
                if (bits_left == '0) begin
                    shreg     <= unit_byte[BYTE_W-1:1];
                    bits_left <= RW'(BYTE_W - 1);
                    stuff_on  <= unit_stuff;
                end else begin
                    shreg     <= shreg >> 1;
                    bits_left <= bits_left - 1'b1;
                end
                if (cur_stuff && cur_bit) begin
                    if (ones_run == 3'd4) begin
                        zero_due <= 1'b1;
                        ones_run <= '0;
                    end else begin
                        ones_run <= ones_run + 1'b1;
                    end
                end else begin
                    ones_run <= '0;
                end
            end
        end
    end

    assert_stuffed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && zero_due) |=> !tx_bit);
    assert_one_bit_per_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
// Frame sequencer: chooses the next unit (flag, data, FCS, abort, idle),
// runs the CRC, and handles underflow and the abort request.
// Assumes unit_req is a single-cycle pulse at each byte boundary.
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_req,
    input  logic              q_empty,
    input  q_entry_t          q_head,
    input  logic              abort_cmd,
    input  logic              underflow_abort,
    input  logic              idle_flags,
    output logic [BYTE_W-1:0] unit_byte,
    output logic              unit_stuff,
    output logic              q_pop,
    output logic              q_flush
);
    tx_state_e   state, state_nx;
    logic [15:0] crc, crc_nx;
    logic        abort_pend;
    logic [15:0] fcs;

    assign fcs = ~crc;

    // Choose the next unit and the state after it.
    always_comb begin
        unit_byte  = idle_flags ? FLAG_BYTE : ONES_BYTE;
        unit_stuff = 1'b0;
        q_pop      = 1'b0;
        q_flush    = 1'b0;
        state_nx   = state;
        crc_nx     = crc;
        if (abort_pend) begin
            unit_byte = ABORT_BYTE;
            q_flush   = unit_req;
            state_nx  = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (!q_empty) begin
                    unit_byte = FLAG_BYTE;
                    state_nx  = ST_DATA;
                    crc_nx    = CRC_PRESET;
                end
                ST_DATA: if (!q_empty) begin
                    unit_byte  = q_head.data;
                    unit_stuff = 1'b1;
                    q_pop      = unit_req;
                    crc_nx     = crc16_step(crc, q_head.data);
                    if (q_head.tag == TAG_END_FCS)      state_nx = ST_FCS_LO;
                    else if (q_head.tag == TAG_END_RAW) state_nx = ST_CLOSE;
                end else begin
                    unit_byte = underflow_abort ? ABORT_BYTE : FLAG_BYTE;
                    state_nx  = ST_IDLE;
                end
                ST_FCS_LO: begin
                    unit_byte  = fcs[7:0];
                    unit_stuff = 1'b1;
                    state_nx   = ST_FCS_HI;
                end
                ST_FCS_HI: begin
                    unit_byte  = fcs[15:8];
                    unit_stuff = 1'b1;
                    state_nx   = ST_CLOSE;
                end
                ST_CLOSE: begin
                    unit_byte = FLAG_BYTE;
                    state_nx  = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Advance state and CRC at each byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            crc   <= CRC_PRESET;
        end else if (unit_req) begin
            state <= state_nx;
            crc   <= crc_nx;
        end
    end

    // Hold an abort request until the next byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_pend <= 1'b0;
        else        abort_pend <= (abort_pend && !unit_req) || abort_cmd;
    end

    assert_abort_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pend && unit_req) |=> (state == ST_IDLE && !abort_pend));
    assert_fcs_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_req && state == ST_FCS_LO && !abort_pend) |=> (state == ST_FCS_HI));
    assert_idle_unstuffed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && q_empty) |-> !unit_stuff);
endmodule

// File: rtl/hdlc_tx_framer.sv
// Top of the HDLC transmitter: tagged-byte queue, frame sequencer and
// bit serializer. Assumes bit_en is a one-cycle strobe per line bit.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] wr_tag,
    input  logic       abort_cmd,
    input  logic       underflow_abort,
    input  logic       idle_flags,
    output logic       fifo_full,
    output logic       tx_bit
);
    q_entry_t          wr_entry, q_head;
    logic              q_empty, q_pop, q_flush, unit_req, unit_stuff;
    logic [BYTE_W-1:0] unit_byte;

    assign wr_entry = '{tag: wr_tag, data: wr_data};

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_entry(wr_entry),
        .pop(q_pop), .flush(q_flush), .rd_entry(q_head),
        .empty(q_empty), .full(fifo_full)
    );

    hdlc_tx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .unit_req(unit_req), .q_empty(q_empty),
        .q_head(q_head), .abort_cmd(abort_cmd), .underflow_abort(underflow_abort),
        .idle_flags(idle_flags), .unit_byte(unit_byte), .unit_stuff(unit_stuff),
        .q_pop(q_pop), .q_flush(q_flush)
    );

    hdlc_tx_bitgen u_bitgen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .unit_byte(unit_byte),
        .unit_stuff(unit_stuff), .unit_req(unit_req), .tx_bit(tx_bit)
    );

    assert_reset_line_high_R1: assert property (@(posedge clk)
        !rst_n |=> (tx_bit && !fifo_full));
endmodule

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_tag = '0;
    logic       abort_cmd = 1'b0;
    logic       underflow_abort = 1'b0;
    logic       idle_flags = 1'b1;
    logic       fifo_full, tx_bit;

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;

    // line decoder state
    logic en_seen = 1'b0;
    int   ones = 0, nb = 0, frames = 0, aborts = 0, flags = 0, zeros = 0;
    bit   hunting = 1;
    logic bb [0:1023];
    logic [7:0] got [0:63];
    int   got_len = 0;
    logic [7:0] exp_b [0:63];
    int   exp_len = 0;

    always #2 clk = ~clk;

    hdlc_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
        .wr_tag(wr_tag), .abort_cmd(abort_cmd), .underflow_abort(underflow_abort),
        .idle_flags(idle_flags), .fifo_full(fifo_full), .tx_bit(tx_bit)
    );

    // Bit strobe: one clock in four.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            bit_en = (div == 0);
        end
    end

    always @(posedge clk) en_seen <= bit_en;

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            if (ones == 7) begin
                aborts++;
                hunting = 1;
                nb = 0;
            end else if (ones < 7 && nb < 1024) begin
                bb[nb] = 1'b1;
                nb++;
            end
        end else begin
            if (ones == 5) begin
                // stuffed zero dropped
            end else if (ones == 6) begin
                flags++;
                if (!hunting && nb >= 7) begin
                    int n;
                    n = nb - 7;
                    if (n > 0 && n % 8 == 0 && n / 8 <= 64) begin
                        for (int k = 0; k < n / 8; k++)
                            for (int i = 0; i < 8; i++) got[k][i] = bb[8*k+i];
                        got_len = n / 8;
                        frames++;
                    end
                end
                hunting = 0;
                nb = 0;
            end else if (nb < 1024) begin
                bb[nb] = 1'b0;
                nb++;
            end
            ones = 0;
        end
    endtask

    // Decode the line one bit after each strobe edge, away from the edge.
    always @(negedge clk) begin
        if (rst_n && en_seen) begin
            if (!tx_bit) zeros++;
            rx_bit(tx_bit);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [1:0] t);
        @(negedge clk);
        while (fifo_full) @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort_cmd = 1'b1;
        @(negedge clk);
        abort_cmd = 1'b0;
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ exp_b[k][i]) c = (c >> 1) ^ 16'h8408;
                else                    c = c >> 1;
            end
        return c;
    endfunction

    task automatic compare_frame(input string req);
        check(got_len == exp_len, req, got_len, exp_len);
        for (int k = 0; k < exp_len && k < got_len; k++)
            check(got[k] == exp_b[k], req, got[k], exp_b[k]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check(tx_bit == 1'b1, "R1 line high in reset", tx_bit, 1);
        check(fifo_full == 1'b0, "R1 queue empty in reset", fifo_full, 0);
        rst_n = 1'b1;
        wait_bits(4);
    endtask

    task automatic t_idle();
        int f0;
        idle_flags = 1'b1;
        wait_bits(10);
        f0 = flags;
        wait_bits(40);
        check(flags - f0 >= 4, "R2 idle flags", flags - f0, 5);
        check(frames == 0, "R2 no frame while idle", frames, 0);
        idle_flags = 1'b0;
        wait_bits(12);
        zeros = 0;
        wait_bits(40);
        check(zeros == 0, "R2 idle ones", zeros, 0);
        idle_flags = 1'b1;
        wait_bits(20);
    endtask

    task automatic t_crc_frame();
        int f0;
        logic [15:0] c;
        f0 = frames;
        for (int k = 0; k < 9; k++) exp_b[k] = 8'h31 + 8'(k);
        c = ref_crc(9);
        exp_b[9] = ~c[7:0];
        exp_b[10] = ~c[15:8];
        exp_len = 11;
        for (int k = 0; k < 9; k++) push(exp_b[k], (k == 8) ? 2'b01 : 2'b00);
        wait_bits(200);
        check(frames == f0 + 1, "R3 one frame with FCS", frames, f0 + 1);
        compare_frame("R4 data then inverted CRC low first");
    endtask

    task automatic t_raw_frame();
        int f0;
        f0 = frames;
        exp_b[0] = 8'hFF; exp_b[1] = 8'hFF; exp_b[2] = 8'h7E; exp_b[3] = 8'hF8;
        exp_len = 4;
        push(exp_b[0], 2'b00);
        push(exp_b[1], 2'b00);
        push(exp_b[2], 2'b00);
        push(exp_b[3], 2'b10);
        @(negedge clk);
        check(fifo_full == 1'b1, "R10 full at four entries", fifo_full, 1);
        wait_bits(120);
        check(frames == f0 + 1, "R5 frame without FCS", frames, f0 + 1);
        compare_frame("R6 stuffed ones decode intact");
    endtask

    task automatic t_underflow_flag();
        int f0, a0;
        f0 = frames; a0 = aborts;
        underflow_abort = 1'b0;
        exp_b[0] = 8'h3C; exp_len = 1;
        push(8'h3C, 2'b00);
        wait_bits(80);
        check(frames == f0 + 1, "R8 underflow closes with flag", frames, f0 + 1);
        check(aborts == a0, "R8 no abort on flag underflow", aborts, a0);
        compare_frame("R8 one byte frame");
    endtask

    task automatic t_underflow_abort();
        int f0, a0;
        f0 = frames; a0 = aborts;
        underflow_abort = 1'b1;
        push(8'h3C, 2'b00);
        wait_bits(80);
        check(aborts == a0 + 1, "R7 underflow sends abort", aborts, a0 + 1);
        check(frames == f0, "R7 no frame delivered", frames, f0);
        underflow_abort = 1'b0;
    endtask

    task automatic t_abort_cmd();
        int f0, a0;
        f0 = frames; a0 = aborts;
        underflow_abort = 1'b0;
        push(8'h11, 2'b00);
        push(8'h22, 2'b00);
        push(8'h33, 2'b00);
        push(8'h44, 2'b00);
        @(negedge clk);
        check(fifo_full == 1'b1, "R10 full before abort", fifo_full, 1);
        pulse_abort();
        wait_bits(20);
        check(fifo_full == 1'b0, "R9 abort empties queue", fifo_full, 0);
        wait_bits(100);
        check(aborts == a0 + 1, "R9 abort byte sent", aborts, a0 + 1);
        check(frames == f0, "R9 flushed bytes never sent", frames, f0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_crc_frame();
        t_raw_frame();
        t_underflow_flag();
        t_underflow_abort();
        t_abort_cmd();
        t_crc_frame();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule